// File: doc/BRIEF.md
# Serial Line Bit-Time Measurement Counter

This block times events on the receive line of a serial port with one 9-bit counter. The mode bits give the counter one of three jobs:

- **Baud recovery.** It counts the time between two falling edges of the line, which gives the incoming baud rate.
- **Break measurement.** It counts how long the line stays low, which gives the length of a received break.
- **Collision detection.** After each rising edge of the port's own transmit output, it counts to a fixed point and looks at the receive line once. A low level there means another node is driving the bus.

The counter advances on one of two enables chosen by a clock-select bit. The first is an external bus-clock divide-by-four strobe. The second is every other pulse of a prescaler strobe. The receive line passes through a synchronizer, then through a one-flop edge detector.

The surrounding logic reads the count as a top bit plus an eight-bit low part, together with four status flags. A write strobe from the control register clears everything and re-arms the counter. This block has no streaming data path: every pin is a plain level or a one-cycle strobe.

Top module: `serial_bit_timer`

## Requirements
- R1: After reset the count is 0 and the running, finished, overflow and collision outputs are all 0.
- R2: While the mode input is 00, the count is held at 0 and all four flags are held at 0 from the next clock edge on. No line or transmit activity starts the counter.
- R3: A pulse on the control-write strobe clears the count and all four flags at the next clock edge and re-arms the counter. The write takes priority over any start, stop or advance in the same cycle.
- R4: With mode 01 and clock-select 0 (edge-to-edge), a synchronized falling edge of RxD starts the counter from 0 and the next such falling edge stops it, setting finished. The running output is high in between. The count advances on each cycle where the bus divide-by-four enable is high. When the enable is high on every cycle and the two falls are L cycles apart at the pin, the final count is L-1.
- R5: With mode 01 and clock-select 1 (low-pulse), the counter starts when the synchronized line is low and stops on its next rising edge, setting finished. The count advances on every second prescaler enable, counted from the start. When the enable is high on every cycle and the pin is low for L cycles, the final count is floor((L-1)/2).
- R6: Suppose the line is already low when the mode leaves 00 for low-pulse measurement. Then counting starts at the first clock edge in the new mode. If the line then stays low for M cycles, the final count is floor((M+1)/2) with the prescaler enable high on every cycle.
- R7: An advance while the count is 0x1FF sets overflow, clears running, and leaves the count frozen at 0x1FF. Finished stays 0, and later line edges are ignored until a clear.
- R8: With mode 10 (arbitration), each rising edge of the transmit input restarts the count from 0, whatever the current state. The counter then advances at the rate chosen by clock-select. On the cycle where the count equals 0x38 (clock-select 0) or 0x08 (clock-select 1), the synchronized RxD is sampled and the counter stops, holding that count.
- R9: In arbitration mode, a low RxD at the sampling point sets collision. Collision stays set across later restarts until a control write or mode 00. A low level that misses the sampling point by one cycle sets nothing.
- R10: The 9-bit count is output as a most-significant-bit port and an eight-bit low port. The count equals {msb, low}.
- R11: Mode 11 behaves exactly like mode 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Receive line, asynchronous |
| txd_i | input | 1 | Transmit output of the port, synchronous |
| bus_div4_en_i | input | 1 | Bus-clock divide-by-four enable |
| presc_en_i | input | 1 | Prescaler enable; counter uses every second pulse |
| mode_i | input | 2 | 00 off, 01/11 measure, 10 arbitration |
| clk_sel_i | input | 1 | 0: edge-to-edge / bus rate; 1: low-pulse / prescaler rate |
| ctrl_wr_i | input | 1 | Control-register write strobe, clears and re-arms |
| cnt_msb_o | output | 1 | Count bit 8 |
| cnt_lsb_o | output | 8 | Count bits 7..0 |
| running_o | output | 1 | Counter is counting |
| finished_o | output | 1 | A measurement ended normally |
| overflow_o | output | 1 | Count ran past 0x1FF |
| collision_o | output | 1 | Low line at the arbitration sampling point |

## Verification
Edge-to-edge timing is swept over every fall-to-fall gap from 4 to 70 cycles with the enable high on every cycle. A second sweep runs with the enable on every fourth cycle. Together these separate an off-by-one in the start or stop edge from an error in enable gating. Low-pulse widths from 3 to 60 cycles, and immediate starts with 1 to 20 further low cycles, check the halving of the prescaler and the phase reset at each start. Gaps of 512, 513 and 600 cycles straddle the overflow point.

For arbitration, a one-cycle low pulse is placed on, just before, and just after the sampling point at both rates. This shows that the sample is taken once and at the right count. A second transmit edge then checks that collision is sticky.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_RUN   = 2'd1,
    ST_STOP  = 2'd2
  } sbt_state_t;

  localparam logic [1:0] MODE_OFF = 2'b00;
  localparam logic [1:0] MODE_ARB = 2'b10;

endpackage

// File: rtl/sbt_rx_sync.sv
module sbt_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s_o,
  output logic fall_o,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // metastability chain, idles high like a serial line
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= line_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign line_s_o = chain_q[STAGES-1];
  assign fall_o   = prev_q & ~chain_q[STAGES-1];
  assign rise_o   = ~prev_q & chain_q[STAGES-1];

endmodule

// File: rtl/sbt_rate.sv
module sbt_rate #(
  parameter int PRE_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_en_i,
  input  logic pre_en_i,
  input  logic sel_i,
  input  logic clr_i,
  output logic adv_o
);

  logic pre_adv;

  generate
    if (PRE_DIV <= 1) begin : g_direct
      assign pre_adv = pre_en_i;
    end else begin : g_div
      localparam int PW = $clog2(PRE_DIV);
      localparam logic [PW-1:0] PH_LAST = PW'(PRE_DIV - 1);
      logic [PW-1:0] ph_q;

      // phase restarts with every measurement so counts are repeatable
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ph_q <= '0;
        else if (clr_i)    ph_q <= '0;
        else if (pre_en_i) ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      end

      assign pre_adv = pre_en_i && (ph_q == PH_LAST);
    end
  endgenerate

  assign adv_o = sel_i ? pre_adv : bus_en_i;

endmodule

// File: rtl/sbt_core.sv
module sbt_core
  import sbt_pkg::*;
#(
  parameter int               CNT_W      = 9,
  parameter logic [CNT_W-1:0] ARB_PT_BUS = 'h38,
  parameter logic [CNT_W-1:0] ARB_PT_PRE = 'h08
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic             txd_i,
  input  logic             rx_s_i,
  input  logic             rx_fall_i,
  input  logic             rx_rise_i,
  input  logic             adv_i,
  output logic             restart_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             fin_o,
  output logic             ovf_o,
  output logic             col_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  sbt_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fin_q, ovf_q, col_q, tx_q;

  logic             off, arb, clear, tx_rise, start_ok, stop_ok, restart;
  logic [CNT_W-1:0] target;

  always_comb begin
    off      = (mode_i == MODE_OFF);
    arb      = (mode_i == MODE_ARB);
    clear    = wr_i | off;
    tx_rise  = txd_i & ~tx_q;
    start_ok = sel_i ? ~rx_s_i : rx_fall_i;
    stop_ok  = sel_i ? rx_rise_i : rx_fall_i;
    target   = sel_i ? ARB_PT_PRE : ARB_PT_BUS;
    restart  = !clear && (arb ? tx_rise : (state_q == ST_ARMED && start_ok));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= 1'b0;
    else        tx_q <= txd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ARMED;
      cnt_q   <= '0;
      fin_q   <= 1'b0;
      ovf_q   <= 1'b0;
      col_q   <= 1'b0;
    end else if (clear) begin
      state_q <= ST_ARMED;
      cnt_q   <= '0;
      fin_q   <= 1'b0;
      ovf_q   <= 1'b0;
      col_q   <= 1'b0;
    end else if (restart) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      fin_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (state_q == ST_RUN) begin
      if (arb && cnt_q == target) begin
        // single static look at the line
        col_q   <= col_q | ~rx_s_i;
        state_q <= ST_STOP;
      end else if (!arb && stop_ok) begin
        fin_q   <= 1'b1;
        state_q <= ST_STOP;
      end else if (adv_i) begin
        if (cnt_q == CNT_MAX) begin
          ovf_q   <= 1'b1;
          state_q <= ST_STOP;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign restart_o = restart | clear;
  assign cnt_o     = cnt_q;
  assign run_o     = (state_q == ST_RUN);
  assign fin_o     = fin_q;
  assign ovf_o     = ovf_q;
  assign col_o     = col_q;

endmodule

// File: rtl/serial_bit_timer.sv
module serial_bit_timer #(
  parameter int               CNT_W       = 9,
  parameter int               SYNC_STAGES = 2,
  parameter int               PRE_DIV     = 2,
  parameter logic [CNT_W-1:0] ARB_PT_BUS  = 'h38,
  parameter logic [CNT_W-1:0] ARB_PT_PRE  = 'h08
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd_i,
  input  logic             txd_i,
  input  logic             bus_div4_en_i,
  input  logic             presc_en_i,
  input  logic [1:0]       mode_i,
  input  logic             clk_sel_i,
  input  logic             ctrl_wr_i,
  output logic             cnt_msb_o,
  output logic [CNT_W-2:0] cnt_lsb_o,
  output logic             running_o,
  output logic             finished_o,
  output logic             overflow_o,
  output logic             collision_o
);

  logic             rx_s, rx_fall, rx_rise, adv, restart;
  logic [CNT_W-1:0] cnt;

  sbt_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (rxd_i),
    .line_s_o (rx_s),
    .fall_o   (rx_fall),
    .rise_o   (rx_rise)
  );

  sbt_rate #(.PRE_DIV(PRE_DIV)) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_en_i (bus_div4_en_i),
    .pre_en_i (presc_en_i),
    .sel_i    (clk_sel_i),
    .clr_i    (restart),
    .adv_o    (adv)
  );

  sbt_core #(
    .CNT_W      (CNT_W),
    .ARB_PT_BUS (ARB_PT_BUS),
    .ARB_PT_PRE (ARB_PT_PRE)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .sel_i     (clk_sel_i),
    .wr_i      (ctrl_wr_i),
    .txd_i     (txd_i),
    .rx_s_i    (rx_s),
    .rx_fall_i (rx_fall),
    .rx_rise_i (rx_rise),
    .adv_i     (adv),
    .restart_o (restart),
    .cnt_o     (cnt),
    .run_o     (running_o),
    .fin_o     (finished_o),
    .ovf_o     (overflow_o),
    .col_o     (collision_o)
  );

  assign cnt_msb_o = cnt[CNT_W-1];
  assign cnt_lsb_o = cnt[CNT_W-2:0];

endmodule

// File: rtl/sbt_chk.sv
module sbt_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             ctrl_wr_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             run_i,
  input logic             fin_i,
  input logic             ovf_i,
  input logic             col_i
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_wr_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_i |=> (cnt_i == '0 && !run_i && !fin_i && !ovf_i && !col_i));

  assert_off_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00) |=> (cnt_i == '0 && !run_i && !fin_i && !ovf_i && !col_i));

  assert_ovf_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_i |-> (cnt_i == CNT_MAX && !run_i && !fin_i));

  assert_run_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (!fin_i && !ovf_i));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !ctrl_wr_i && mode_i != 2'b00) |=>
      (cnt_i == $past(cnt_i) || cnt_i == CNT_W'($past(cnt_i) + 1'b1) || cnt_i == '0));

  assert_col_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (col_i && !ctrl_wr_i && mode_i != 2'b00) |=> col_i);

endmodule

bind serial_bit_timer sbt_chk #(.CNT_W(CNT_W)) u_sbt_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_i    (mode_i),
  .ctrl_wr_i (ctrl_wr_i),
  .cnt_i     ({cnt_msb_o, cnt_lsb_o}),
  .run_i     (running_o),
  .fin_i     (finished_o),
  .ovf_i     (overflow_o),
  .col_i     (collision_o)
);

// File: tb/tb_serial_bit_timer.sv
module tb_serial_bit_timer;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1, txd = 1'b0, d4 = 1'b0, ps = 1'b0, cwr = 1'b0, cs = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       cnt_msb, running, finished, overflow, collision;
  logic [7:0] cnt_lsb;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_bit_timer dut (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .txd_i(txd),
    .bus_div4_en_i(d4), .presc_en_i(ps), .mode_i(mode), .clk_sel_i(cs),
    .ctrl_wr_i(cwr), .cnt_msb_o(cnt_msb), .cnt_lsb_o(cnt_lsb),
    .running_o(running), .finished_o(finished), .overflow_o(overflow),
    .collision_o(collision)
  );

  function automatic int cnt_now();
    return int'({cnt_msb, cnt_lsb});
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // inputs set at the falling edge, seen by the next rising edge
  task automatic drv(input logic r, input logic t, input logic a, input logic b, input logic w);
    @(negedge clk);
    rxd = r; txd = t; d4 = a; ps = b; cwr = w;
  endtask

  task automatic run_e2e(input int L, input int P, input logic [1:0] md);
    int n;
    drv(1, 0, 0, 0, 1); mode = md; cs = 1'b0;
    for (int i = 0; i <= L + 4; i++) begin
      drv((i == 0 || i == 1 || i == L || i == L + 1) ? 1'b0 : 1'b1, 0, (i % P) == 0, 0, 0);
      if (i == 4) chk("R4 running while counting", int'(running), 1);
    end
    n = 0;
    for (int k = 3; k <= L + 1; k++) if ((k % P) == 0) n++;
    if (n >= 512) begin
      chk("R7 count frozen", cnt_now(), 511);
      chk("R7 overflow set", int'(overflow), 1);
      chk("R7 finished clear", int'(finished), 0);
      chk("R7 running clear", int'(running), 0);
    end else begin
      chk(md == 2'b11 ? "R11 count" : "R4 count", cnt_now(), n);
      chk("R4 finished", int'(finished), 1);
      chk("R4 stopped", int'(running), 0);
      chk("R10 msb field", int'(cnt_msb), (n >> 8) & 1);
      chk("R10 low field", int'(cnt_lsb), n & 255);
    end
  endtask

  task automatic run_lp(input int L);
    drv(1, 0, 0, 0, 1); mode = 2'b01; cs = 1'b1;
    for (int i = 0; i <= L + 4; i++) begin
      drv((i < L) ? 1'b0 : 1'b1, 0, 0, 1, 0);
      if (i == 4 && L >= 3) chk("R5 running", int'(running), 1);
    end
    chk("R5 count", cnt_now(), (L - 1) / 2);
    chk("R5 finished", int'(finished), 1);
  endtask

  task automatic run_imm(input int M);
    drv(0, 0, 0, 0, 0); mode = 2'b00;
    repeat (3) drv(0, 0, 0, 0, 0);
    chk("R2 idle while line low", int'(running), 0);
    drv(0, 0, 0, 1, 0); mode = 2'b01; cs = 1'b1;
    for (int i = 1; i <= M + 4; i++) begin
      drv((i < M) ? 1'b0 : 1'b1, 0, 0, 1, 0);
      if (i == 1) chk("R6 immediate start", int'(running), 1);
    end
    chk("R6 count", cnt_now(), (M + 1) / 2);
    chk("R6 finished", int'(finished), 1);
  endtask

  task automatic run_arb(input logic c, input int lo, input int S);
    int t_end;
    int tgt;
    t_end = c ? 17 : 57;
    tgt   = c ? 8 : 56;
    drv(1, 0, 0, 0, 1); mode = 2'b10; cs = c;
    for (int i = 0; i <= t_end + 3; i++) begin
      drv((i == lo) ? 1'b0 : 1'b1, 1, !c, c, 0);
      if (i == 5) chk("R8 running after tx rise", int'(running), 1);
    end
    chk("R8 count at sample point", cnt_now(), tgt);
    chk("R8 stopped", int'(running), 0);
    chk("R9 collision", int'(collision), (lo == S) ? 1 : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", cnt_now(), 0);
    chk("R1 flags", int'({running, finished, overflow, collision}), 0);

    // R2: off mode ignores every input
    drv(1, 0, 0, 0, 0); mode = 2'b00;
    for (int i = 0; i < 24; i++) begin
      drv((i % 3) != 0, (i % 2) != 0, 1, 1, 0);
      if (i > 0) chk("R2 held", cnt_now() + int'(running), 0);
    end
    repeat (3) drv(1, 0, 0, 0, 0);

    for (int L = 4; L <= 70; L++) run_e2e(L, 1, 2'b01);
    for (int L = 6; L <= 40; L++) run_e2e(L, 4, 2'b01);
    run_e2e(10, 1, 2'b11);
    run_e2e(23, 3, 2'b11);
    for (int L = 3; L <= 60; L++) run_lp(L);
    for (int M = 1; M <= 20; M++) run_imm(M);

    run_e2e(512, 1, 2'b01);
    run_e2e(513, 1, 2'b01);
    drv(1, 0, 0, 0, 1);
    drv(1, 0, 0, 0, 0);
    chk("R3 write clears overflow", int'(overflow), 0);
    chk("R3 write clears count", cnt_now(), 0);
    run_e2e(600, 1, 2'b01);
    drv(1, 0, 0, 0, 0); mode = 2'b00;
    drv(1, 0, 0, 0, 0);
    chk("R2 off clears overflow", int'(overflow), 0);

    for (int c = 0; c < 2; c++) begin
      int S;
      S = (c != 0) ? 15 : 55;
      run_arb(c[0], S - 1, S);
      run_arb(c[0], S + 1, S);
      run_arb(c[0], -1, S);
      run_arb(c[0], S, S);
    end

    run_arb(1'b0, 55, 55);
    drv(1, 0, 1, 0, 0);
    for (int i = 0; i <= 60; i++) drv(1, 1, 1, 0, 0);
    chk("R9 collision sticky", int'(collision), 1);
    chk("R8 restart count", cnt_now(), 56);
    drv(1, 0, 0, 0, 1);
    drv(1, 0, 0, 0, 0);
    chk("R3 write clears collision", int'(collision), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule